// File: doc/BRIEF.md
# Indexed Register Window with Interrupt Flags

This block gives a host processor access to a 64-byte register space through only two bus locations. Address bit `a0` low selects a pointer register that names one of the 64 bytes. Address bit `a0` high opens a data window onto the byte that the pointer names. The low bytes hold timekeeping and control registers. Two of those bytes are status bytes that can only be read, and two bits in other bytes are protected against writes. The bytes from 0x0E upward are plain storage for the host.

The block is the bus front end of a timekeeping core. The core signals three events with one-cycle pulses: a periodic tick, an alarm match and the end of an update. Each event sets a sticky flag. An enable bit in control byte 0x0B lets each flag raise an active-low, open-drain interrupt request. Because that request is open drain, the block only reports when the pin should be pulled low.

The bus strobes are sampled on the system clock, and the block acts on the rising edge of the write and read strobes. There is no stream traffic, so every pin is a plain control or data signal. The tri-state data bus is modelled as a data vector plus an output-enable.

Top module: `ixp_top`

## Requirements
- R1: A write with `a0`=0 loads the low 6 bits of `din` into the pointer register. A read with `a0`=0 returns the pointer with bits 7:6 as zero.
- R2: With `a0`=1, writes and reads go to the byte that the pointer selects. The user bytes 0x0E–0x3F keep whatever was last written to them.
- R3: Byte 0x0C (status) and byte 0x0D are read-only. Byte 0x0D always reads 0x80, and writes to either byte change nothing.
- R4: Bit 7 of byte 0x00 and bit 7 of byte 0x0A always read 0 and cannot be written. Bits 6:0 of those bytes are stored normally.
- R5: A write takes effect only on a rising edge of `wr_n` while `cs_n` is low. A low `wr_n` alone changes nothing. `dout_en` is high only while `rd_n` and `cs_n` are low and `stby_n` and `rst_n` are high.
- R6: Pulses on `pf_in`, `af_in` and `uf_in` set sticky flags that read back as bits 6, 5 and 4 of byte 0x0C. The flags are set whatever the enable bits are.
- R7: Bit 7 of byte 0x0C equals (PF&PIE)|(AF&AIE)|(UF&UIE). The enables are bits 6, 5 and 4 of byte 0x0B. `irq_oe` (pull the interrupt line low) follows bit 7.
- R8: When a read of byte 0x0C completes (rising edge of `rd_n`), all flags clear. A flag pulse in that same cycle wins, and its flag stays set.
- R9: While `rst_n` is low, the block clears bits 6:3 of byte 0x0B and all flags, holds `irq_oe` low and ignores the bus. Other stored bits keep their values.
- R10: While `stby_n` is low, writes are ignored and `dout_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| stby_n | input | 1 | Active-low standby; blocks all access |
| cs_n | input | 1 | Active-low select |
| a0 | input | 1 | 0 = pointer register, 1 = data window |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus (zero when not driven) |
| dout_en | output | 1 | Drive enable for the bus |
| pf_in | input | 1 | Periodic event pulse from the core |
| af_in | input | 1 | Alarm event pulse from the core |
| uf_in | input | 1 | Update-ended event pulse from the core |
| irq_oe | output | 1 | High = pull the open-drain interrupt line low |

## Verification
The bench uses the default parameters: a 6-bit pointer and 8-bit bytes. With those values the full 64-byte space lies in reach of random pointer values, including pointer writes whose bits 7:6 must be dropped. Random data is written to every user byte and read back against a model. Directed sequences cover the protected bits, the status read that clears the flags while a new flag pulse arrives, each enable gating the interrupt, and the control bits that reset clears while the user bytes keep their values.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
  localparam int unsigned IDX_W  = 6;
  localparam int unsigned DATA_W = 8;

  localparam int unsigned REG_SEC  = 'h00;
  localparam int unsigned REG_CTLA = 'h0A;
  localparam int unsigned REG_CTLB = 'h0B;
  localparam int unsigned REG_STAT = 'h0C;
  localparam int unsigned REG_VLD  = 'h0D;

  // enable bit positions inside control byte B
  localparam int unsigned B_PIE  = 6;
  localparam int unsigned B_AIE  = 5;
  localparam int unsigned B_UIE  = 4;
  localparam int unsigned B_SQWE = 3;

  localparam logic [7:0] VLD_VALUE  = 8'h80;
  localparam logic [7:0] B_RST_MASK = 8'h78;

  // bits a host may change in a given byte
  function automatic logic [7:0] host_mask(input int unsigned idx);
    if (idx == REG_STAT || idx == REG_VLD)     return 8'h00;
    else if (idx == REG_SEC || idx == REG_CTLA) return 8'h7F;
    else                                        return 8'hFF;
  endfunction
endpackage

// File: rtl/ixp_strobe.sv
module ixp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic wr_n,
  input  logic rd_n,
  output logic wr_commit,
  output logic rd_done
);
  logic wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  // completion of a strobe: low last cycle, high now, still selected
  assign wr_commit = sel & wr_n & ~wr_q;
  assign rd_done   = sel & rd_n & ~rd_q;
endmodule

// File: rtl/ixp_regfile.sv
module ixp_regfile
  import ixp_pkg::*;
#(
  parameter int unsigned P_IDX_W  = IDX_W,
  parameter int unsigned P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [P_IDX_W-1:0]  idx,
  input  logic [P_DATA_W-1:0] wdata,
  output logic [P_DATA_W-1:0] rdata,
  output logic [P_DATA_W-1:0] ctrl_b
);
  localparam int unsigned NUM_REGS = 1 << P_IDX_W;

  logic [P_DATA_W-1:0] store [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    localparam logic [P_DATA_W-1:0] MASK = P_DATA_W'(host_mask(g));
    if (MASK == '0) begin : g_ro
      assign store[g] = '0;
    end else begin : g_rw
      logic [P_DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          if (g == REG_CTLB) q <= q & ~P_DATA_W'(B_RST_MASK);
        end else if (we && idx == P_IDX_W'(g)) begin
          q <= (q & ~MASK) | (wdata & MASK);
        end
      end
      assign store[g] = q & MASK;
    end
  end

  assign rdata  = store[idx];
  assign ctrl_b = store[REG_CTLB];
endmodule

// File: rtl/ixp_irq.sv
module ixp_irq
  import ixp_pkg::*;
#(
  parameter int unsigned P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pf_in,
  input  logic                af_in,
  input  logic                uf_in,
  input  logic                clr,
  input  logic [P_DATA_W-1:0] ctrl_b,
  output logic [P_DATA_W-1:0] status,
  output logic                irq_oe
);
  logic [2:0] flags;
  logic [2:0] enables;
  logic       irqf;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? 3'b000 : flags) | {pf_in, af_in, uf_in};
  end

  assign enables = {ctrl_b[B_PIE], ctrl_b[B_AIE], ctrl_b[B_UIE]};
  assign irqf    = |(flags & enables);
  assign status  = {irqf, flags, {(P_DATA_W-4){1'b0}}};
  assign irq_oe  = irqf & rst_n;
endmodule

// File: rtl/ixp_top.sv
module ixp_top
  import ixp_pkg::*;
#(
  parameter int unsigned P_IDX_W  = IDX_W,
  parameter int unsigned P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stby_n,
  input  logic                cs_n,
  input  logic                a0,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [P_DATA_W-1:0] din,
  output logic [P_DATA_W-1:0] dout,
  output logic                dout_en,
  input  logic                pf_in,
  input  logic                af_in,
  input  logic                uf_in,
  output logic                irq_oe
);
  logic                sel, wr_commit, rd_done, stat_clr;
  logic [P_IDX_W-1:0]  index;
  logic [P_DATA_W-1:0] rdata, ctrl_b, status, rd_val;

  assign sel = ~cs_n & stby_n & rst_n;

  ixp_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_n(wr_n), .rd_n(rd_n),
    .wr_commit(wr_commit), .rd_done(rd_done)
  );

  always_ff @(posedge clk) begin
    if (wr_commit && !a0) index <= din[P_IDX_W-1:0];
  end

  ixp_regfile #(.P_IDX_W(P_IDX_W), .P_DATA_W(P_DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_commit & a0), .idx(index),
    .wdata(din), .rdata(rdata), .ctrl_b(ctrl_b)
  );

  assign stat_clr = rd_done & a0 & (index == P_IDX_W'(REG_STAT));

  ixp_irq #(.P_DATA_W(P_DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .pf_in(pf_in), .af_in(af_in), .uf_in(uf_in),
    .clr(stat_clr), .ctrl_b(ctrl_b), .status(status), .irq_oe(irq_oe)
  );

  always_comb begin
    if (!a0)                               rd_val = P_DATA_W'(index);
    else if (index == P_IDX_W'(REG_STAT))  rd_val = status;
    else if (index == P_IDX_W'(REG_VLD))   rd_val = P_DATA_W'(VLD_VALUE);
    else                                   rd_val = rdata;
  end

  assign dout_en = sel & ~rd_n;
  assign dout    = dout_en ? rd_val : '0;
endmodule

// File: rtl/ixp_chk.sv
module ixp_chk
  import ixp_pkg::*;
#(
  parameter int unsigned P_IDX_W  = IDX_W,
  parameter int unsigned P_DATA_W = DATA_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stby_n,
  input logic                cs_n,
  input logic                a0,
  input logic                rd_n,
  input logic                pf_in,
  input logic                af_in,
  input logic                uf_in,
  input logic                dout_en,
  input logic                irq_oe,
  input logic                wr_commit,
  input logic                rd_done,
  input logic [P_IDX_W-1:0]  index,
  input logic [P_DATA_W-1:0] ctrl_b
);
  assert_drive_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!cs_n && !rd_n && stby_n));

  assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |-> (!dout_en && !wr_commit));

  assert_irq_released_R9: assert property (@(posedge clk)
    !rst_n |-> !irq_oe);

  assert_pf_raises_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_in && ctrl_b[B_PIE] && !wr_commit) |=> irq_oe);

  assert_status_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && a0 && index == P_IDX_W'(REG_STAT) && !pf_in && !af_in && !uf_in)
      |=> !irq_oe);

  assert_index_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_commit && !a0) |=> $stable(index));
endmodule

bind ixp_top ixp_chk #(.P_IDX_W(P_IDX_W), .P_DATA_W(P_DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .cs_n(cs_n), .a0(a0), .rd_n(rd_n),
  .pf_in(pf_in), .af_in(af_in), .uf_in(uf_in), .dout_en(dout_en), .irq_oe(irq_oe),
  .wr_commit(wr_commit), .rd_done(rd_done), .index(index), .ctrl_b(ctrl_b)
);

// File: tb/sim_ixp_top.sv
module sim_ixp_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, stby_n = 1'b1, cs_n = 1'b1, a0 = 1'b0;
  logic       rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en, irq_oe;
  logic       pf_in = 1'b0, af_in = 1'b0, uf_in = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [64];
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  ixp_top u0 (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .cs_n(cs_n), .a0(a0),
    .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout), .dout_en(dout_en),
    .pf_in(pf_in), .af_in(af_in), .uf_in(uf_in), .irq_oe(irq_oe)
  );

  function automatic logic [7:0] ro_mask(input int idx);
    if (idx == 'h00 || idx == 'h0A) return 8'h7F;
    return 8'hFF;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel_a0, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; a0 = sel_a0; din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic sel_a0, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; a0 = sel_a0; rd_n = 1'b0;
    #1 d = dout;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic reg_write(input int idx, input logic [7:0] d);
    bus_write(1'b0, 8'(idx));
    bus_write(1'b1, d);
  endtask

  task automatic reg_read(input int idx, output logic [7:0] d);
    bus_write(1'b0, 8'(idx));
    bus_read(1'b1, d);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    pf_in = (which == 0); af_in = (which == 1); uf_in = (which == 2);
    @(negedge clk); pf_in = 1'b0; af_in = 1'b0; uf_in = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1497));
    // R9: reset state
    repeat (3) @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    check("R9 drive blocked in reset", {7'b0, dout_en}, 8'h00);
    check("R9 irq released in reset", {7'b0, irq_oe}, 8'h00);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R1: pointer register
    bus_write(1'b0, 8'h25); bus_read(1'b0, got); check("R1 pointer readback", got, 8'h25);
    bus_write(1'b0, 8'hFF); bus_read(1'b0, got); check("R1 pointer upper bits", got, 8'h3F);

    // R2: random user bytes through the window
    for (int i = 14; i < 64; i++) begin
      model[i] = 8'($urandom);
      reg_write(i, model[i]);
    end
    for (int k = 0; k < 40; k++) begin
      int i = 14 + int'($urandom % 50);
      model[i] = 8'($urandom);
      reg_write(i, model[i]);
    end
    for (int i = 14; i < 64; i++) begin
      reg_read(i, got); check("R2 user byte", got, model[i]);
    end
    for (int i = 1; i < 10; i++) begin
      model[i] = 8'($urandom);
      reg_write(i, model[i]);
      reg_read(i, got); check("R2 clock byte", got, model[i] & ro_mask(i));
    end

    // R4: protected bit 7
    reg_write('h00, 8'hFF); reg_read('h00, got); check("R4 seconds bit7", got, 8'h7F);
    reg_write('h0A, 8'hAA); reg_read('h0A, got); check("R4 byte A bit7", got, 8'h2A);

    // R3: read-only status bytes
    reg_write('h0B, 8'h00);
    reg_write('h0C, 8'hFF); reg_read('h0C, got); check("R3 status write ignored", got, 8'h00);
    reg_write('h0D, 8'h00); reg_read('h0D, got); check("R3 byte D constant", got, 8'h80);

    // R6 / R8: flags without enables
    pulse(0);
    check("R7 no enable no irq", {7'b0, irq_oe}, 8'h00);
    reg_read('h0C, got); check("R6 periodic flag", got, 8'h40);
    reg_read('h0C, got); check("R8 read clears", got, 8'h00);

    // R7: enable gating per source
    reg_write('h0B, 8'h40);
    pulse(1);
    check("R7 alarm masked", {7'b0, irq_oe}, 8'h00);
    reg_read('h0C, got); check("R6 alarm flag", got, 8'h20);
    pulse(0);
    check("R7 periodic raises irq", {7'b0, irq_oe}, 8'h01);
    reg_read('h0C, got); check("R7 irqf bit", got, 8'hC0);
    check("R8 irq released after read", {7'b0, irq_oe}, 8'h00);
    reg_write('h0B, 8'h10);
    pulse(2);
    check("R7 update raises irq", {7'b0, irq_oe}, 8'h01);
    reg_read('h0C, got); check("R7 update flags", got, 8'h90);
    reg_write('h0B, 8'h20);
    pulse(1);
    check("R7 alarm raises irq", {7'b0, irq_oe}, 8'h01);
    reg_read('h0C, got); check("R7 alarm flags", got, 8'hA0);

    // R8: pulse in the same cycle as the clearing read wins
    reg_write('h0B, 8'h10);
    bus_write(1'b0, 8'h0C);
    @(negedge clk); cs_n = 1'b0; a0 = 1'b1; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; pf_in = 1'b1;
    @(negedge clk); pf_in = 1'b0; cs_n = 1'b1;
    bus_read(1'b1, got); check("R8 set beats clear", got, 8'h40);

    // R5: strobe rules
    reg_write('h20, 8'h11);
    @(negedge clk); cs_n = 1'b0; a0 = 1'b1; din = 8'h77; wr_n = 1'b0;
    @(negedge clk); @(negedge clk); cs_n = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    bus_read(1'b1, got); check("R5 no edge no write", got, 8'h11);
    @(negedge clk); cs_n = 1'b1; a0 = 1'b1; din = 8'h99; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    bus_read(1'b1, got); check("R5 unselected write", got, 8'h11);
    @(negedge clk); rd_n = 1'b0; #1;
    check("R5 no drive unselected", {7'b0, dout_en}, 8'h00);
    @(negedge clk); rd_n = 1'b1;

    // R10: standby
    @(negedge clk); stby_n = 1'b0;
    bus_write(1'b1, 8'h5A);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    check("R10 no drive in standby", {7'b0, dout_en}, 8'h00);
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1; stby_n = 1'b1;
    bus_read(1'b1, got); check("R10 write ignored", got, 8'h11);

    // R9: reset clears enables and flags, keeps storage
    reg_write('h30, 8'hA5);
    reg_write('h0B, 8'hFF);
    pulse(0);
    check("R9 irq before reset", {7'b0, irq_oe}, 8'h01);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R9 irq released at once", {7'b0, irq_oe}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_read('h0B, got); check("R9 control bits cleared", got, 8'h87);
    reg_read('h0C, got); check("R9 flags cleared", got, 8'h00);
    reg_read('h30, got); check("R9 storage kept", got, 8'hA5);

    summary();
  end
endmodule